// File: doc/BRIEF.md
# Instruction Reuse Predictor Table

This block keeps one reuse counter per memory-access instruction, selected by a slice of that instruction's program counter. It learns how well data brought in by each instruction is reused over time. A cache controller asks the table what it thinks of an instruction and gets back a five-level reuse class. The controller can use that class to choose an insertion position or to bypass the cache entirely.

Training arrives on a separate update port. The controller reports whether an access by that instruction reused data that was already present, or touched the data for the first time. A reuse raises the counter by one and a first touch lowers it by one. The counters stop at both ends of their range and do not wrap. The prediction port and the update port work independently, so both can be used in the same cycle.

Top module: `pc_reuse_filter`

## Requirements
- R1: After reset, every entry holds the mid-scale value 128, so any prediction returns count 128 and class code 2.
- R2: The entry is selected by PC bits [10:2] (nine bits above two alignment bits). Bits below and above that slice do not change which entry is used.
- R3: An update with `upd_reuse_i`=1 raises the selected counter by exactly one.
- R4: An update with `upd_reuse_i`=0 lowers the selected counter by exactly one.
- R5: A counter at 255 stays at 255 when it is raised again.
- R6: A counter at 0 stays at 0 when it is lowered again.
- R7: The class code is a function of the count: 0 below 32, 1 for 32 to 95, 2 for 96 to 159, 3 for 160 to 223, and 4 for 224 or more.
- R8: `pred_valid_o` is high in the cycle after a request and low in the cycle after a cycle with no request. The count and class it qualifies belong to that request.
- R9: When a prediction and an update select the same entry in the same cycle, the prediction reports the value from before that update.
- R10: An update changes only the entry it selects. An entry that is not updated keeps its value between predictions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pred_valid_i | input | 1 | Prediction request |
| pred_pc_i | input | 32 | PC of the instruction to predict |
| upd_valid_i | input | 1 | Training update |
| upd_pc_i | input | 32 | PC of the instruction being trained |
| upd_reuse_i | input | 1 | 1 = data reuse (raise), 0 = first touch (lower) |
| pred_valid_o | output | 1 | Prediction result valid |
| pred_count_o | output | 8 | Counter value of the predicted entry |
| pred_class_o | output | 3 | Reuse class code, 0 (bypass) to 4 (strong reuse) |

## Verification
A prediction is sampled in the cycle after its request, at the falling edge that follows the next rising edge. The bench drives a request at one falling edge and compares the outputs at the next falling edge. The expected value is taken from the bench's model before that cycle's update is applied, which covers the same-entry case. An update applies at the rising edge that ends its cycle, so a prediction issued in any later cycle already sees it. The bench model applies each update immediately after it takes that cycle's prediction snapshot.

// File: rtl/pc_reuse_pkg.sv
package pc_reuse_pkg;

  typedef enum logic [2:0] {
    CLS_SKIP = 3'd0,
    CLS_WEAK = 3'd1,
    CLS_MID  = 3'd2,
    CLS_GOOD = 3'd3,
    CLS_HOT  = 3'd4
  } reuse_cls_e;

  typedef struct packed {
    logic rdEn;
    logic wrEn;
    logic wrUp;
  } tbl_strobe_t;

endpackage

// File: rtl/pc_reuse_ctrl.sv
module pc_reuse_ctrl
  import pc_reuse_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ALIGN_W = 2,
  parameter int IDX_W   = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               predValid,
  input  logic [PC_W-1:0]    predPc,
  input  logic               updValid,
  input  logic [PC_W-1:0]    updPc,
  input  logic               updReuse,
  output tbl_strobe_t        strobe,
  output logic [IDX_W-1:0]   rdIdx,
  output logic [IDX_W-1:0]   wrIdx,
  output logic               resValid
);

  // Index slice sits right above the alignment bits
  assign rdIdx = predPc[ALIGN_W +: IDX_W];
  assign wrIdx = updPc[ALIGN_W +: IDX_W];

  always_comb begin
    strobe.rdEn = predValid;
    strobe.wrEn = updValid;
    strobe.wrUp = updReuse;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) resValid <= 1'b0;
    else        resValid <= predValid;
  end

endmodule

// File: rtl/pc_reuse_classify.sv
module pc_reuse_classify
  import pc_reuse_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] count,
  output reuse_cls_e       cls
);

  // Four equal bands of a quarter scale, the lowest band split in half
  localparam int STEP     = 1 << (CNT_W - 2);
  localparam int TH_WEAK  = STEP / 2;
  localparam int TH_MID   = TH_WEAK + STEP;
  localparam int TH_GOOD  = TH_MID + STEP;
  localparam int TH_HOT   = TH_GOOD + STEP;

  always_comb begin
    if (count >= CNT_W'(TH_HOT))       cls = CLS_HOT;
    else if (count >= CNT_W'(TH_GOOD)) cls = CLS_GOOD;
    else if (count >= CNT_W'(TH_MID))  cls = CLS_MID;
    else if (count >= CNT_W'(TH_WEAK)) cls = CLS_WEAK;
    else                               cls = CLS_SKIP;
  end

endmodule

// File: rtl/pc_reuse_datapath.sv
module pc_reuse_datapath
  import pc_reuse_pkg::*;
#(
  parameter int IDX_W = 9,
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  tbl_strobe_t        strobe,
  input  logic [IDX_W-1:0]   rdIdx,
  input  logic [IDX_W-1:0]   wrIdx,
  output logic [CNT_W-1:0]   rdCount,
  output reuse_cls_e         rdClass
);

  localparam int              ENTRIES = 1 << IDX_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_MID = CNT_W'(1 << (CNT_W - 1));

  logic [CNT_W-1:0] cntArr [ENTRIES];
  logic [CNT_W-1:0] curVal;
  logic [CNT_W-1:0] nextVal;

  assign curVal = cntArr[wrIdx];

  // Saturating step, shared by all entries
  always_comb begin
    nextVal = curVal;
    if (strobe.wrUp) begin
      if (curVal != CNT_MAX) nextVal = curVal + 1'b1;
    end else begin
      if (curVal != '0) nextVal = curVal - 1'b1;
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)
        cntArr[e] <= CNT_MID;
      else if (strobe.wrEn && wrIdx == IDX_W'(e))
        cntArr[e] <= nextVal;
    end
  end

  // Registered read sees contents before this edge's write
  always_ff @(posedge clk) begin
    if (!rst_n)           rdCount <= CNT_MID;
    else if (strobe.rdEn) rdCount <= cntArr[rdIdx];
  end

  pc_reuse_classify #(.CNT_W(CNT_W)) u_cls (
    .count (rdCount),
    .cls   (rdClass)
  );

endmodule

// File: rtl/pc_reuse_filter.sv
module pc_reuse_filter
  import pc_reuse_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ALIGN_W = 2,
  parameter int IDX_W   = 9,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pred_valid_i,
  input  logic [PC_W-1:0]  pred_pc_i,
  input  logic             upd_valid_i,
  input  logic [PC_W-1:0]  upd_pc_i,
  input  logic             upd_reuse_i,
  output logic             pred_valid_o,
  output logic [CNT_W-1:0] pred_count_o,
  output logic [2:0]       pred_class_o
);

  tbl_strobe_t      strobe;
  logic [IDX_W-1:0] rdIdx;
  logic [IDX_W-1:0] wrIdx;
  reuse_cls_e       rdClass;

  pc_reuse_ctrl #(.PC_W(PC_W), .ALIGN_W(ALIGN_W), .IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .predValid (pred_valid_i),
    .predPc    (pred_pc_i),
    .updValid  (upd_valid_i),
    .updPc     (upd_pc_i),
    .updReuse  (upd_reuse_i),
    .strobe    (strobe),
    .rdIdx     (rdIdx),
    .wrIdx     (wrIdx),
    .resValid  (pred_valid_o)
  );

  pc_reuse_datapath #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .rdIdx   (rdIdx),
    .wrIdx   (wrIdx),
    .rdCount (pred_count_o),
    .rdClass (rdClass)
  );

  assign pred_class_o = rdClass;

endmodule

// File: rtl/pc_reuse_filter_chk.sv
module pc_reuse_filter_chk #(
  parameter int PC_W    = 32,
  parameter int ALIGN_W = 2,
  parameter int IDX_W   = 9,
  parameter int CNT_W   = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pred_valid_i,
  input logic [PC_W-1:0]  pred_pc_i,
  input logic             upd_valid_i,
  input logic [PC_W-1:0]  upd_pc_i,
  input logic             pred_valid_o,
  input logic [CNT_W-1:0] pred_count_o,
  input logic [2:0]       pred_class_o
);

  localparam int Q = 1 << (CNT_W - 2);

  function automatic logic [2:0] bandOf(input logic [CNT_W-1:0] c);
    int v;
    v = int'(c);
    if (v < Q / 2)        return 3'd0;
    if (v < Q / 2 + Q)    return 3'd1;
    if (v < Q / 2 + 2*Q)  return 3'd2;
    if (v < Q / 2 + 3*Q)  return 3'd3;
    return 3'd4;
  endfunction

  logic [IDX_W-1:0] pIdx, uIdx;
  assign pIdx = pred_pc_i[ALIGN_W +: IDX_W];
  assign uIdx = upd_pc_i[ALIGN_W +: IDX_W];

  p_pred_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid_i |=> pred_valid_o);

  p_pred_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_valid_i |=> !pred_valid_o);

  p_class_band_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid_o |-> pred_class_o == bandOf(pred_count_o));

  p_class_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid_o |-> pred_class_o <= 3'd4);

  // Same entry read twice with no update to it in between keeps its count
  p_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid_i && $past(pred_valid_i) && $past(pIdx) == pIdx &&
     !($past(upd_valid_i) && $past(uIdx) == pIdx))
    |=> pred_count_o == $past(pred_count_o));

endmodule

bind pc_reuse_filter pc_reuse_filter_chk #(
  .PC_W(PC_W), .ALIGN_W(ALIGN_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pred_valid_i (pred_valid_i),
  .pred_pc_i    (pred_pc_i),
  .upd_valid_i  (upd_valid_i),
  .upd_pc_i     (upd_pc_i),
  .pred_valid_o (pred_valid_o),
  .pred_count_o (pred_count_o),
  .pred_class_o (pred_class_o)
);

// File: tb/pc_reuse_filter_test.sv
`timescale 1ns/1ps
module pc_reuse_filter_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pred_valid_i = 1'b0;
  logic [31:0] pred_pc_i = '0;
  logic        upd_valid_i = 1'b0;
  logic [31:0] upd_pc_i = '0;
  logic        upd_reuse_i = 1'b0;
  logic        pred_valid_o;
  logic [7:0]  pred_count_o;
  logic [2:0]  pred_class_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int model [512];
  bit pendValid = 0;
  int pendCount = 0;
  string pendTag = "";

  always #4 clk = ~clk;

  pc_reuse_filter uut (.*);

  function automatic int idxOf(input logic [31:0] pc);
    return int'(pc[10:2]);
  endfunction

  function automatic int expClass(input int c);
    if (c < 32)  return 0;
    if (c < 96)  return 1;
    if (c < 160) return 2;
    if (c < 224) return 3;
    return 4;
  endfunction

  function automatic logic [31:0] mkPc(input int idx);
    logic [31:0] r;
    r = $urandom;
    r[10:2] = idx[8:0];
    return r;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Called at a falling edge: check the previous request, drive the next one
  task automatic cycle(input bit pv, input logic [31:0] ppc,
                       input bit uv, input logic [31:0] upc, input bit ur,
                       input string tag);
    check("R8", "valid", int'(pred_valid_o), int'(pendValid));
    if (pendValid) begin
      check(pendTag, "count", int'(pred_count_o), pendCount);
      check({pendTag, " R7"}, "class", int'(pred_class_o), expClass(pendCount));
    end
    pred_valid_i = pv; pred_pc_i = ppc;
    upd_valid_i = uv;  upd_pc_i = upc; upd_reuse_i = ur;
    pendValid = pv;
    pendTag = tag;
    if (pv) pendCount = model[idxOf(ppc)];
    if (uv) begin
      if (ur && model[idxOf(upc)] < 255) model[idxOf(upc)]++;
      if (!ur && model[idxOf(upc)] > 0)  model[idxOf(upc)]--;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    cycle(0, '0, 0, '0, 0, "");
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    foreach (model[i]) model[i] = 128;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int i = 0; i < 40; i++) cycle(1, mkPc(int'($urandom % 512)), 0, '0, 0, "R1");
    idle();
    // R3 single step and R9 same-entry collision
    cycle(1, mkPc(7), 1, mkPc(7), 1, "R9");
    cycle(1, mkPc(7), 0, '0, 0, "R3");
    cycle(1, mkPc(7), 1, mkPc(7), 0, "R9");
    cycle(1, mkPc(7), 0, '0, 0, "R4");
    // R5 saturate high with walk through upper classes
    for (int i = 0; i < 140; i++) cycle(1, mkPc(20), 1, mkPc(20), 1, "R5 R3");
    cycle(1, mkPc(20), 0, '0, 0, "R5");
    // R6 floor with walk through lower classes
    for (int i = 0; i < 140; i++) cycle(1, mkPc(21), 1, mkPc(21), 0, "R6 R4");
    cycle(1, mkPc(21), 0, '0, 0, "R6");
    // R10 neighbours untouched
    cycle(1, mkPc(19), 0, '0, 0, "R10");
    cycle(1, mkPc(22), 0, '0, 0, "R10");
    // R2 aliasing: trained by one PC, read by another with same slice
    for (int i = 0; i < 30; i++) cycle(0, '0, 1, 32'hA000_0000 | (32'd300 << 2) | 32'd1, 1, "");
    cycle(1, 32'h0000_0000 | (32'd300 << 2) | 32'd3, 0, '0, 0, "R2");
    cycle(1, 32'h7FF0_0000 | (32'd300 << 2), 0, '0, 0, "R2");
    cycle(1, 32'd301 << 2, 0, '0, 0, "R2 R10");
    // Random mix over a small set of entries so extremes are reached
    for (int i = 0; i < 6000; i++) begin
      int pi, ui;
      pi = 40 + int'($urandom % 6);
      ui = 40 + int'($urandom % 6);
      cycle(($urandom % 4) != 0, mkPc(pi), ($urandom % 3) != 0, mkPc(ui),
            ($urandom % 2) == 0, "R3 R4 R9");
    end
    idle();
    idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule